// File: doc/BRIEF.md
# Masked Golden Compare with Error Statistics

This block watches a design under test and a golden copy of it running side by side on the same stimulus. On every run cycle it compares the two 72-bit output words. Only the bit positions that the host has enabled in an output mask take part in the compare. A cycle with at least one enabled bit that differs counts as one error cycle.

From the error stream it keeps three saturating 32-bit statistics: how many error cycles have been seen, how many cycles have passed since the first error, and how many cycles have passed since the latest error. The host reads one statistic at a time through a statistic select. Through a second, data select it reads any 32-bit slice of the stimulus word or of either output word. While the test is halted the statistics freeze. A synchronous clear restarts them.

Top module: `golden_cmp_stats`

## Requirements
- R1: A run cycle is an error cycle exactly when the design-under-test word and the golden word differ in at least one bit position whose mask bit is 1. Bits 63:0 take their mask bit from the programmed mask. Bits 71:64 always count as enabled.
- R2: The error count rises by exactly one per error cycle with run_en high, however many bits differ in that cycle.
- R3: The since-first statistic stays 0 until the first error cycle. It also stays 0 in the error cycle itself. From the following run cycle on it rises by one on every run cycle, error or not.
- R4: The since-last statistic is 0 after every error cycle. On run cycles without an error it rises by one once a first error has been seen, and stays 0 before that.
- R5: Every statistic saturates at 2^CNT_W-1 and never wraps.
- R6: While run_en is low, no statistic changes, even if the two output words differ.
- R7: stats_clr high at a clock edge sets all three statistics to zero and forgets the first error. It takes priority over run_en and over any error in the same cycle.
- R8: stat_sel selects the statistic on stat_rdata: 0 gives the error count, 1 gives since-first and 2 gives since-last, each zero-extended to 32 bits. Code 3 reads as zero.
- R9: data_rdata follows data_sel. Codes 0, 1 and 2 give stimulus bits 31:0, 63:32 and 71:64. Codes 3 to 5 give the same three slices of dut_vec, and codes 6 to 8 give them for gold_vec. The 71:64 slices are zero-extended. Codes 9 to 15 read as zero.
- R10: After reset the programmed mask is all ones. A pulse on mask_wr_lo loads mask_wdata into mask bits 31:0, and a pulse on mask_wr_hi loads it into bits 63:32. The new mask applies from the next cycle.
- R11: After reset all three statistics read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | High on cycles where the test runs and is compared |
| stats_clr | input | 1 | Synchronous clear of the statistics |
| mask_wr_lo | input | 1 | Load mask bits 31:0 from mask_wdata |
| mask_wr_hi | input | 1 | Load mask bits 63:32 from mask_wdata |
| mask_wdata | input | 32 | Mask write data |
| stim_vec | input | 72 | Stimulus word applied to both copies |
| dut_vec | input | 72 | Output of the design under test |
| gold_vec | input | 72 | Output of the golden copy |
| stat_sel | input | 2 | Statistic select |
| data_sel | input | 4 | Data slice select |
| stat_rdata | output | 32 | Selected statistic |
| data_rdata | output | 32 | Selected data slice |

## Verification
On every cycle the assertions check these rules:
- a clear zeroes all three statistics;
- a halted cycle holds them;
- an error cycle zeroes since-last and steps the error count by one below its ceiling;
- saturated counters stay saturated;
- since-last never exceeds since-first.

Some behaviours only the bench scenarios can show. These are the bit-by-bit effect of the mask, including the always-enabled top byte and the one-cycle latency of a mask write. They also cover the exact onset of the since-first count, the priority of clear over an error, and the mapping of every select code to its slice.

// File: rtl/gcs_pkg.sv
`timescale 1ns/1ps
package gcs_pkg;

   // statistic select codes
   typedef enum logic [1:0] {
      STAT_ERRS  = 2'd0,
      STAT_FIRST = 2'd1,
      STAT_LAST  = 2'd2
   } stat_sel_e;

   // data sources in slice-select order
   localparam int NUM_SRC  = 3;
   localparam int SRC_STIM = 0;
   localparam int SRC_DUT  = 1;
   localparam int SRC_GOLD = 2;

endpackage

// File: rtl/gcs_mask_reg.sv
`timescale 1ns/1ps
module gcs_mask_reg #(
   parameter int DATA_W = 72,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [WORD_W-1:0] wdata,
   output logic [DATA_W-1:0] mask
);
   localparam int PROG_W = 2 * WORD_W;

   logic [WORD_W-1:0] lo_q;
   logic [WORD_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '1;
         hi_q <= '1;
      end else begin
         if (wr_lo) lo_q <= wdata;
         if (wr_hi) hi_q <= wdata;
      end
   end

   generate
      if (DATA_W > PROG_W) begin : g_fixed_top
         // bits beyond the two programmable halves are always compared
         assign mask = {{(DATA_W - PROG_W){1'b1}}, hi_q, lo_q};
      end else begin : g_trunc
         logic [PROG_W-1:0] both;
         assign both = {hi_q, lo_q};
         assign mask = both[DATA_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/gcs_compare.sv
`timescale 1ns/1ps
module gcs_compare #(
   parameter int DATA_W = 72
) (
   input  logic [DATA_W-1:0] dut_w,
   input  logic [DATA_W-1:0] gold_w,
   input  logic [DATA_W-1:0] mask,
   output logic              hit
);
   logic [DATA_W-1:0] diff;

   assign diff = (dut_w ^ gold_w) & mask;
   assign hit  = |diff;

endmodule

// File: rtl/gcs_sat_counter.sv
`timescale 1ns/1ps
module gcs_sat_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         zero,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q <= '0;
      else if (clr || zero)       q <= '0;
      else if (inc && q != TOP)   q <= q + 1'b1;
   end

endmodule

// File: rtl/gcs_read_mux.sv
`timescale 1ns/1ps
module gcs_read_mux
   import gcs_pkg::*;
#(
   parameter int DATA_W = 72,
   parameter int WORD_W = 32,
   parameter int CNT_W  = 32,
   parameter int DSEL_W = 4
) (
   input  logic [1:0]        stat_sel,
   input  logic [DSEL_W-1:0] data_sel,
   input  logic [CNT_W-1:0]  cnt_err,
   input  logic [CNT_W-1:0]  cnt_first,
   input  logic [CNT_W-1:0]  cnt_last,
   input  logic [DATA_W-1:0] stim_w,
   input  logic [DATA_W-1:0] dut_w,
   input  logic [DATA_W-1:0] gold_w,
   output logic [WORD_W-1:0] stat_rdata,
   output logic [WORD_W-1:0] data_rdata
);
   localparam int NSLICE = (DATA_W + WORD_W - 1) / WORD_W;
   localparam int PAD_W  = NSLICE * WORD_W;
   localparam int NCODE  = NUM_SRC * NSLICE;

   logic [DATA_W-1:0] src_vec [NUM_SRC];
   logic [WORD_W-1:0] words   [NCODE];

   assign src_vec[SRC_STIM] = stim_w;
   assign src_vec[SRC_DUT]  = dut_w;
   assign src_vec[SRC_GOLD] = gold_w;

   generate
      for (genvar k = 0; k < NCODE; k++) begin : g_word
         logic [PAD_W-1:0] pad;
         assign pad      = PAD_W'(src_vec[k / NSLICE]);
         assign words[k] = pad[(k % NSLICE) * WORD_W +: WORD_W];
      end
   endgenerate

   always_comb begin
      data_rdata = '0;
      for (int k = 0; k < NCODE; k++) begin
         if (data_sel == DSEL_W'(k)) data_rdata = words[k];
      end
   end

   always_comb begin
      case (stat_sel)
         STAT_ERRS:  stat_rdata = WORD_W'(cnt_err);
         STAT_FIRST: stat_rdata = WORD_W'(cnt_first);
         STAT_LAST:  stat_rdata = WORD_W'(cnt_last);
         default:    stat_rdata = '0;
      endcase
   end

endmodule

// File: rtl/golden_cmp_stats.sv
`timescale 1ns/1ps
module golden_cmp_stats
   import gcs_pkg::*;
#(
   parameter int DATA_W = 72,
   parameter int WORD_W = 32,
   parameter int CNT_W  = 32,
   parameter int DSEL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              stats_clr,
   input  logic              mask_wr_lo,
   input  logic              mask_wr_hi,
   input  logic [WORD_W-1:0] mask_wdata,
   input  logic [DATA_W-1:0] stim_vec,
   input  logic [DATA_W-1:0] dut_vec,
   input  logic [DATA_W-1:0] gold_vec,
   input  logic [1:0]        stat_sel,
   input  logic [DSEL_W-1:0] data_sel,
   output logic [WORD_W-1:0] stat_rdata,
   output logic [WORD_W-1:0] data_rdata
);
   localparam int NSLICE = (DATA_W + WORD_W - 1) / WORD_W;
   localparam int NCODE  = NUM_SRC * NSLICE;

   generate
      if (CNT_W < 1 || CNT_W > WORD_W) begin : g_bad_cnt
         $error("CNT_W must lie between 1 and WORD_W");
      end
      if ((1 << DSEL_W) < NCODE) begin : g_bad_dsel
         $error("DSEL_W too narrow for the slice codes");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W too small");
      end
   endgenerate

   logic [DATA_W-1:0] full_mask;
   logic              err_hit;
   logic              seen_q;
   logic              err_step;
   logic              tick_after;
   logic [CNT_W-1:0]  cnt_err;
   logic [CNT_W-1:0]  cnt_first;
   logic [CNT_W-1:0]  cnt_last;

   gcs_mask_reg #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (mask_wr_lo),
      .wr_hi (mask_wr_hi),
      .wdata (mask_wdata),
      .mask  (full_mask)
   );

   gcs_compare #(.DATA_W(DATA_W)) u_cmp (
      .dut_w  (dut_vec),
      .gold_w (gold_vec),
      .mask   (full_mask),
      .hit    (err_hit)
   );

   assign err_step   = run_en && err_hit;
   assign tick_after = run_en && seen_q;

   // remembers that a first error has occurred
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_q <= 1'b0;
      else if (stats_clr) seen_q <= 1'b0;
      else if (err_step)  seen_q <= 1'b1;
   end

   gcs_sat_counter #(.W(CNT_W)) u_cnt_err (
      .clk (clk), .rst_n (rst_n), .clr (stats_clr),
      .zero (1'b0), .inc (err_step), .q (cnt_err)
   );

   gcs_sat_counter #(.W(CNT_W)) u_cnt_first (
      .clk (clk), .rst_n (rst_n), .clr (stats_clr),
      .zero (1'b0), .inc (tick_after), .q (cnt_first)
   );

   gcs_sat_counter #(.W(CNT_W)) u_cnt_last (
      .clk (clk), .rst_n (rst_n), .clr (stats_clr),
      .zero (err_step), .inc (tick_after), .q (cnt_last)
   );

   gcs_read_mux #(
      .DATA_W (DATA_W), .WORD_W (WORD_W), .CNT_W (CNT_W), .DSEL_W (DSEL_W)
   ) u_rd (
      .stat_sel   (stat_sel),
      .data_sel   (data_sel),
      .cnt_err    (cnt_err),
      .cnt_first  (cnt_first),
      .cnt_last   (cnt_last),
      .stim_w     (stim_vec),
      .dut_w      (dut_vec),
      .gold_w     (gold_vec),
      .stat_rdata (stat_rdata),
      .data_rdata (data_rdata)
   );

endmodule

// File: rtl/gcs_chk.sv
`timescale 1ns/1ps
module gcs_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             stats_clr,
   input logic             err_hit,
   input logic [CNT_W-1:0] cnt_err,
   input logic [CNT_W-1:0] cnt_first,
   input logic [CNT_W-1:0] cnt_last
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      stats_clr |=> (cnt_err == '0 && cnt_first == '0 && cnt_last == '0));

   a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !stats_clr) |=>
         ($stable(cnt_err) && $stable(cnt_first) && $stable(cnt_last)));

   a_r4_last_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !stats_clr && err_hit) |=> cnt_last == '0);

   a_r2_err_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !stats_clr && err_hit && cnt_err != TOP) |=>
         cnt_err == CNT_W'($past(cnt_err) + 1'b1));

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!stats_clr && cnt_err == TOP) |=> cnt_err == TOP);

   a_r5_first_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!stats_clr && cnt_first == TOP) |=> cnt_first == TOP);

   a_r3_last_within_first: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_last <= cnt_first);

   a_r3_idle_before_first: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_err == '0 |-> (cnt_first == '0 && cnt_last == '0));

endmodule

bind golden_cmp_stats gcs_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .stats_clr (stats_clr),
   .err_hit   (err_hit),
   .cnt_err   (cnt_err),
   .cnt_first (cnt_first),
   .cnt_last  (cnt_last)
);

// File: tb/tb_golden_cmp_stats.sv
`timescale 1ns/1ps
module tb_golden_cmp_stats;
   localparam int CW  = 4;
   localparam int MAX = (1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        stats_clr = 1'b0;
   logic        mask_wr_lo = 1'b0;
   logic        mask_wr_hi = 1'b0;
   logic [31:0] mask_wdata = '0;
   logic [71:0] stim_vec = '0;
   logic [71:0] dut_vec = '0;
   logic [71:0] gold_vec = '0;
   logic [1:0]  stat_sel = '0;
   logic [3:0]  data_sel = '0;
   logic [31:0] stat_rdata;
   logic [31:0] data_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // bench model state
   int m_err = 0, m_first = 0, m_last = 0;
   bit m_seen = 0;
   logic [31:0] m_lo = '1, m_hi = '1;

   always #5 clk = ~clk;

   golden_cmp_stats #(.CNT_W(CW)) dut (
      .clk (clk), .rst_n (rst_n), .run_en (run_en), .stats_clr (stats_clr),
      .mask_wr_lo (mask_wr_lo), .mask_wr_hi (mask_wr_hi), .mask_wdata (mask_wdata),
      .stim_vec (stim_vec), .dut_vec (dut_vec), .gold_vec (gold_vec),
      .stat_sel (stat_sel), .data_sel (data_sel),
      .stat_rdata (stat_rdata), .data_rdata (data_rdata)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic int sat(input int v);
      return (v >= MAX) ? MAX : v + 1;
   endfunction

   // R8: read all select codes, 3 must read zero
   task automatic check_stats(input string req);
      for (int s = 0; s < 4; s++) begin
         logic [31:0] e;
         stat_sel = s[1:0];
         #1;
         e = (s == 0) ? m_err : (s == 1) ? m_first : (s == 2) ? m_last : 0;
         chk($sformatf("%s R8 sel%0d", req, s), stat_rdata, e);
      end
   endtask

   task automatic step(input bit run, input bit clr, input logic [71:0] d, input logic [71:0] g);
      logic [71:0] diff;
      bit e, old_seen;
      @(negedge clk);
      run_en = run; stats_clr = clr; dut_vec = d; gold_vec = g;
      @(posedge clk);
      #1;
      run_en = 0; stats_clr = 0;
      diff = (d ^ g) & {8'hFF, m_hi, m_lo};
      e = (diff != '0);
      old_seen = m_seen;
      if (clr) begin
         m_err = 0; m_first = 0; m_last = 0; m_seen = 0;
      end else if (run) begin
         if (old_seen) m_first = sat(m_first);
         if (e) begin
            m_err = sat(m_err); m_last = 0; m_seen = 1;
         end else if (old_seen) m_last = sat(m_last);
      end
   endtask

   task automatic write_mask(input logic [31:0] lo, input logic [31:0] hi);
      @(negedge clk);
      mask_wr_lo = 1; mask_wr_hi = 1; mask_wdata = lo;
      @(negedge clk);
      mask_wr_hi = 0; mask_wr_lo = 0;
      @(negedge clk);
      mask_wr_hi = 1; mask_wdata = hi;
      @(negedge clk);
      mask_wr_hi = 0;
      m_lo = lo; m_hi = hi;
   endtask

   task automatic bit_sweep(input string req);
      step(1, 1, '0, '0);
      for (int b = 0; b < 72; b++) begin
         step(1, 0, 72'd1 << b, '0);
         check_stats($sformatf("%s bit%0d", req, b));
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R11: reset state
      check_stats("R11 reset");

      // R10: reset mask is all ones, so bit 0 differs -> error
      step(1, 0, 72'd1, '0);
      check_stats("R10 reset mask");
      // R3: first error cycle leaves since-first at 0, next run cycle gives 1
      step(1, 0, '0, '0);
      check_stats("R3 onset");
      chk("R3 since_first one", m_first, 1);

      // R1 / R10: sweeps over every bit under several masks
      write_mask(32'h0, 32'h0);
      bit_sweep("R1 mask zero");
      write_mask(32'h0000_FFFF, 32'hF0F0_F0F0);
      bit_sweep("R1 mask mixed");
      write_mask(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      bit_sweep("R10 mask ones");

      // R10: a mask write takes effect the cycle after it is written
      step(1, 1, '0, '0);
      @(negedge clk);
      mask_wr_lo = 1; mask_wdata = 32'h0; run_en = 1; dut_vec = 72'd1; gold_vec = '0;
      @(posedge clk); #1;
      mask_wr_lo = 0; run_en = 0;
      m_err = 1; m_seen = 1; m_lo = 32'h0;
      check_stats("R10 write latency");
      step(1, 0, 72'd1, '0);
      check_stats("R10 new mask applied");

      // R2: many differing bits still count once
      step(1, 1, '0, '0);
      step(1, 0, {72{1'b1}}, '0);
      check_stats("R2 multi-bit");
      chk("R2 single count", m_err, 1);

      // R4: since-last restarts on each error
      step(1, 0, '0, '0);
      step(1, 0, '0, '0);
      check_stats("R4 grows");
      step(1, 0, 72'h80 << 64, '0);
      check_stats("R4 cleared");

      // R5: saturation
      step(1, 1, '0, '0);
      for (int i = 0; i < 20; i++) step(1, 0, 72'h1 << 70, '0);
      check_stats("R5 err sat");
      for (int i = 0; i < 20; i++) step(1, 0, '0, '0);
      check_stats("R5 since sat");

      // R6: halted cycles hold despite mismatch
      step(1, 1, '0, '0);
      step(1, 0, 72'h1 << 66, '0);
      step(1, 0, '0, '0);
      for (int i = 0; i < 5; i++) step(0, 0, {72{1'b1}}, '0);
      check_stats("R6 halt");
      chk("R6 held first", m_first, 1);

      // R7: clear wins over a simultaneous error
      step(1, 1, 72'h1 << 71, '0);
      check_stats("R7 clear priority");
      step(1, 0, '0, '0);
      check_stats("R7 first forgotten");

      // R9: every data select code
      stim_vec = {8'hA5, 32'h1234_5678, 32'h9ABC_DEF0};
      dut_vec  = {8'h3C, 32'hCAFE_F00D, 32'h0BAD_BEEF};
      gold_vec = {8'hE1, 32'h5555_AAAA, 32'h0F0F_1234};
      for (int c = 0; c < 16; c++) begin
         logic [71:0] v;
         logic [31:0] e;
         data_sel = c[3:0];
         #1;
         v = (c / 3 == 0) ? stim_vec : (c / 3 == 1) ? dut_vec : gold_vec;
         e = (c < 9) ? 32'(v >> (32 * (c % 3))) : 32'h0;
         chk($sformatf("R9 code%0d", c), data_rdata, e);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule